// File: doc/BRIEF.md
# Configurable Logic Control Cell

This block is one storage cell of a programmable logic fabric. It receives four sum-of-products terms (`sum_a` to `sum_d`) from a product-term array that lies outside the block. It also receives a set of global controls shared by every cell. A set of configuration inputs decides how the cell uses them. Those settings choose the register kind (D, T or JK), whether sum B acts as the K input, a preset or a plain path, and whether sum C acts as a reset or a plain path. They also choose whether sum D acts as an output enable or a feedback node, and which source clocks the register.

The whole cell runs on one system clock `clk`. The register-clock source is sampled on `clk`, and a rising transition of the selected source is the register's active edge. That source can be the global high-speed clock with programmable polarity, sum C or sum D. A global run-time control can override the configured register kind. It puts the cell in D mode to load a value and in T mode to count. Each of the `NUM_OUT` cell outputs independently shows the register state or one of the sums A, B or C.

Top module: `lcc_cell`

## Requirements
- R1: After the system reset `rst` (synchronous, active high), the register state is 0. The active-edge detector is armed so that a source already high when reset ends gives no edge.
- R2: The register kind is selected by `cfg_kind`: 0 is D, 1 is T, 2 is JK, and 3 behaves as D. In D mode, an active edge stores sum A.
- R3: In T mode, an active edge inverts the state when sum A is 1 and leaves it unchanged when sum A is 0.
- R4: In JK mode, J is sum A. K is sum B when `cfg_b_role` is 1 and 0 otherwise. On an active edge, J/K = 1/1 inverts the state, 0/0 holds it, 1/0 sets it and 0/1 clears it.
- R5: On an active edge, `glb_rst` clears the state and otherwise `glb_pre` sets it. When both are high, reset wins. Without an active edge, neither has any effect.
- R6: Sum C is an immediate reset when `cfg_c_role` is 1. Sum B is an immediate preset when `cfg_b_role` is 2. Both act on the visible state within the same cycle, without waiting for an edge, and reset wins over preset. The register keeps the forced value after they are released.
- R7: `cfg_clk_src` selects the register-clock source: 0 is the global clock, 1 is sum C, 2 is sum D and 3 is none. An edge on any source that is not selected has no effect.
- R8: With `glb_clk_neg` = 1, the falling edge of `glb_clk` is the active edge and the rising edge is ignored.
- R9: With `cfg_dyn_en` = 1, the register kind is D while `glb_load` is 1 and T while it is 0, whatever `cfg_kind` says.
- R10: Output `cell_out[i]` is chosen by the two bits `cfg_out_sel[2i+1:2i]`: 0 is the register state, 1 is sum A, 2 is sum B and 3 is sum C.
- R11: With `cfg_d_role` = 1, `oe_o` follows sum D and `fb_o` is 0. With `cfg_d_role` = 0, `fb_o` follows sum D and `oe_o` is 1.
- R12: Without an active edge, changes on sum A and sum B leave the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every source |
| rst | input | 1 | Synchronous active-high system reset |
| sum_a | input | 1 | Sum term A: data, T or J input |
| sum_b | input | 1 | Sum term B: K input, preset or path |
| sum_c | input | 1 | Sum term C: clock, reset or path |
| sum_d | input | 1 | Sum term D: clock, output enable or feedback |
| glb_clk | input | 1 | Global high-speed clock line |
| glb_clk_neg | input | 1 | 1 selects the falling global-clock edge |
| glb_rst | input | 1 | Global edge-timed reset |
| glb_pre | input | 1 | Global edge-timed preset |
| glb_load | input | 1 | Run-time kind control: 1 load (D), 0 count (T) |
| cfg_kind | input | 2 | Register kind: 0 D, 1 T, 2 JK, 3 D |
| cfg_dyn_en | input | 1 | Lets glb_load override the register kind |
| cfg_b_role | input | 2 | Sum B role: 0 path, 1 K, 2 preset |
| cfg_c_role | input | 1 | Sum C role: 0 path, 1 reset |
| cfg_d_role | input | 1 | Sum D role: 0 feedback, 1 output enable |
| cfg_clk_src | input | 2 | Clock source: 0 global, 1 sum C, 2 sum D, 3 none |
| cfg_out_sel | input | 2*NUM_OUT | Two select bits per cell output |
| cell_out | output | NUM_OUT | Selected cell outputs |
| oe_o | output | 1 | Output-enable signal for the pin cell |
| fb_o | output | 1 | Buried feedback node |

## Verification
The hardest cases to reach from the ports are those where the active edge depends on how the clock source and the global polarity interact. Changing the polarity or the source selection while a source line is high can create an edge that nobody intended. The stimulus therefore changes the polarity only while the global line is high, and switches sources only while all sums are 0. This allows the falling-edge case to be isolated from the rising-edge case. For the register kinds, a near-exhaustive sweep first sets the starting state through the global preset or reset. It then applies every A/B pair and compares the result with the next state computed from the D, T and JK rules.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    typedef enum logic [1:0] {
        REG_D   = 2'd0,
        REG_T   = 2'd1,
        REG_JK  = 2'd2,
        REG_RSV = 2'd3
    } reg_kind_e;

    typedef enum logic [1:0] {
        B_PATH   = 2'd0,
        B_K      = 2'd1,
        B_PRESET = 2'd2,
        B_RSV    = 2'd3
    } b_role_e;

    typedef enum logic [1:0] {
        CK_GLOBAL = 2'd0,
        CK_SUMC   = 2'd1,
        CK_SUMD   = 2'd2,
        CK_NONE   = 2'd3
    } clk_src_e;

    typedef enum logic [1:0] {
        O_Q = 2'd0,
        O_A = 2'd1,
        O_B = 2'd2,
        O_C = 2'd3
    } out_src_e;

    localparam int SEL_W = 2;

    typedef struct packed {
        logic a;
        logic b;
        logic c;
        logic d;
    } sums_t;

    typedef struct packed {
        logic sync_rst;
        logic sync_pre;
        logic async_rst;
        logic async_pre;
    } ctrl_t;

    function automatic logic next_state(reg_kind_e kind, logic q, logic j, logic k);
        logic nq;
        case (kind)
            REG_T:   nq = q ^ j;
            REG_JK: begin
                case ({j, k})
                    2'b11:   nq = ~q;
                    2'b10:   nq = 1'b1;
                    2'b01:   nq = 1'b0;
                    default: nq = q;
                endcase
            end
            default: nq = j;
        endcase
        return nq;
    endfunction

    function automatic reg_kind_e pick_kind(logic [1:0] cfg, logic dyn_en, logic load);
        reg_kind_e k;
        if (dyn_en) begin
            k = load ? REG_D : REG_T;
        end else begin
            k = reg_kind_e'(cfg);
        end
        return k;
    endfunction

endpackage

// File: rtl/lcc_clk_edge.sv
module lcc_clk_edge
    import lcc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  clk_src_e src_sel,
    input  logic     glb_clk,
    input  logic     glb_clk_neg,
    input  logic     sum_c,
    input  logic     sum_d,
    output logic     edge_act
);

    logic src_now;
    logic src_prev;

    always_comb begin
        case (src_sel)
            CK_GLOBAL: src_now = glb_clk ^ glb_clk_neg;
            CK_SUMC:   src_now = sum_c;
            CK_SUMD:   src_now = sum_d;
            default:   src_now = 1'b0;
        endcase
    end

    // Reset to 1 so a source already high at reset release gives no edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            src_prev <= 1'b1;
        end else begin
            src_prev <= src_now;
        end
    end

    assign edge_act = src_now & ~src_prev;

endmodule

// File: rtl/lcc_reg_core.sv
module lcc_reg_core
    import lcc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      edge_act,
    input  reg_kind_e kind,
    input  logic      j_in,
    input  logic      k_in,
    input  ctrl_t     ctrl,
    output logic      q_reg,
    output logic      q_vis
);

    logic q_next;

    always_comb begin
        q_next = next_state(kind, q_reg, j_in, k_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q_reg <= 1'b0;
        end else if (ctrl.async_rst) begin
            q_reg <= 1'b0;
        end else if (ctrl.async_pre) begin
            q_reg <= 1'b1;
        end else if (edge_act) begin
            if (ctrl.sync_rst) begin
                q_reg <= 1'b0;
            end else if (ctrl.sync_pre) begin
                q_reg <= 1'b1;
            end else begin
                q_reg <= q_next;
            end
        end
    end

    // Sum-sourced reset/preset reach the visible state without a clock.
    always_comb begin
        if (ctrl.async_rst) begin
            q_vis = 1'b0;
        end else if (ctrl.async_pre) begin
            q_vis = 1'b1;
        end else begin
            q_vis = q_reg;
        end
    end

endmodule

// File: rtl/lcc_out_mux.sv
module lcc_out_mux
    import lcc_pkg::*;
#(
    parameter int NUM_OUT = 2
) (
    input  logic [SEL_W*NUM_OUT-1:0] sel_flat,
    input  logic                     q_vis,
    input  sums_t                    sums,
    output logic [NUM_OUT-1:0]       outs
);

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        out_src_e sel;
        assign sel = out_src_e'(sel_flat[SEL_W*i +: SEL_W]);
        always_comb begin
            case (sel)
                O_A:     outs[i] = sums.a;
                O_B:     outs[i] = sums.b;
                O_C:     outs[i] = sums.c;
                default: outs[i] = q_vis;
            endcase
        end
    end

endmodule

// File: rtl/lcc_cell.sv
module lcc_cell
    import lcc_pkg::*;
#(
    parameter int NUM_OUT = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sum_a,
    input  logic                     sum_b,
    input  logic                     sum_c,
    input  logic                     sum_d,
    input  logic                     glb_clk,
    input  logic                     glb_clk_neg,
    input  logic                     glb_rst,
    input  logic                     glb_pre,
    input  logic                     glb_load,
    input  logic [1:0]               cfg_kind,
    input  logic                     cfg_dyn_en,
    input  logic [1:0]               cfg_b_role,
    input  logic                     cfg_c_role,
    input  logic                     cfg_d_role,
    input  logic [1:0]               cfg_clk_src,
    input  logic [SEL_W*NUM_OUT-1:0] cfg_out_sel,
    output logic [NUM_OUT-1:0]       cell_out,
    output logic                     oe_o,
    output logic                     fb_o
);

    sums_t     sums;
    ctrl_t     ctrl;
    reg_kind_e kind_eff;
    b_role_e   b_role;
    logic      k_in;
    logic      edge_act;
    logic      q_reg;
    logic      q_vis;

    assign sums   = '{a: sum_a, b: sum_b, c: sum_c, d: sum_d};
    assign b_role = b_role_e'(cfg_b_role);

    always_comb begin
        kind_eff       = pick_kind(cfg_kind, cfg_dyn_en, glb_load);
        k_in           = (b_role == B_K) ? sums.b : 1'b0;
        ctrl.sync_rst  = glb_rst;
        ctrl.sync_pre  = glb_pre;
        ctrl.async_rst = cfg_c_role & sums.c;
        ctrl.async_pre = (b_role == B_PRESET) & sums.b;
    end

    lcc_clk_edge i_clk_edge (
        .clk         (clk),
        .rst         (rst),
        .src_sel     (clk_src_e'(cfg_clk_src)),
        .glb_clk     (glb_clk),
        .glb_clk_neg (glb_clk_neg),
        .sum_c       (sums.c),
        .sum_d       (sums.d),
        .edge_act    (edge_act)
    );

    lcc_reg_core i_reg_core (
        .clk      (clk),
        .rst      (rst),
        .edge_act (edge_act),
        .kind     (kind_eff),
        .j_in     (sums.a),
        .k_in     (k_in),
        .ctrl     (ctrl),
        .q_reg    (q_reg),
        .q_vis    (q_vis)
    );

    lcc_out_mux #(.NUM_OUT(NUM_OUT)) i_out_mux (
        .sel_flat (cfg_out_sel),
        .q_vis    (q_vis),
        .sums     (sums),
        .outs     (cell_out)
    );

    assign oe_o = cfg_d_role ? sums.d : 1'b1;
    assign fb_o = cfg_d_role ? 1'b0 : sums.d;

endmodule

// File: rtl/lcc_cell_chk.sv
module lcc_cell_chk (
    input logic       clk,
    input logic       rst,
    input logic       edge_act,
    input logic [1:0] kind_eff,
    input logic       q_reg,
    input logic       sum_a,
    input logic       glb_rst,
    input logic       glb_pre,
    input logic       async_rst,
    input logic       async_pre
);

    logic quiet;
    assign quiet = !async_rst && !async_pre && !glb_rst && !glb_pre;

    AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (q_reg == 1'b0)); // R1

    AST_D_LOAD: assert property (@(posedge clk) disable iff (rst)
        (edge_act && quiet && (kind_eff == 2'd0 || kind_eff == 2'd3))
        |=> (q_reg == $past(sum_a))); // R2

    AST_T_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (edge_act && quiet && kind_eff == 2'd1)
        |=> (q_reg == ($past(q_reg) ^ $past(sum_a)))); // R3

    AST_GLB_RST_WINS: assert property (@(posedge clk) disable iff (rst)
        (edge_act && glb_rst && !async_rst && !async_pre) |=> (q_reg == 1'b0)); // R5

    AST_ASYNC_RST: assert property (@(posedge clk) disable iff (rst)
        async_rst |=> (q_reg == 1'b0)); // R6

    AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
        (!edge_act && !async_rst && !async_pre) |=> $stable(q_reg)); // R12

endmodule

bind lcc_cell lcc_cell_chk i_lcc_cell_chk (
    .clk       (clk),
    .rst       (rst),
    .edge_act  (edge_act),
    .kind_eff  (kind_eff),
    .q_reg     (q_reg),
    .sum_a     (sum_a),
    .glb_rst   (glb_rst),
    .glb_pre   (glb_pre),
    .async_rst (ctrl.async_rst),
    .async_pre (ctrl.async_pre)
);

// File: tb/test_lcc_cell.sv
`timescale 1ns/1ps
module test_lcc_cell;

    localparam int NUM_OUT = 2;

    logic clk = 1'b0;
    logic rst;
    logic sum_a, sum_b, sum_c, sum_d;
    logic glb_clk, glb_clk_neg, glb_rst, glb_pre, glb_load;
    logic [1:0] cfg_kind, cfg_b_role, cfg_clk_src;
    logic cfg_dyn_en, cfg_c_role, cfg_d_role;
    logic [2*NUM_OUT-1:0] cfg_out_sel;
    logic [NUM_OUT-1:0] cell_out;
    logic oe_o, fb_o;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    lcc_cell #(.NUM_OUT(NUM_OUT)) i_lcc_cell (
        .clk(clk), .rst(rst),
        .sum_a(sum_a), .sum_b(sum_b), .sum_c(sum_c), .sum_d(sum_d),
        .glb_clk(glb_clk), .glb_clk_neg(glb_clk_neg),
        .glb_rst(glb_rst), .glb_pre(glb_pre), .glb_load(glb_load),
        .cfg_kind(cfg_kind), .cfg_dyn_en(cfg_dyn_en), .cfg_b_role(cfg_b_role),
        .cfg_c_role(cfg_c_role), .cfg_d_role(cfg_d_role), .cfg_clk_src(cfg_clk_src),
        .cfg_out_sel(cfg_out_sel), .cell_out(cell_out), .oe_o(oe_o), .fb_o(fb_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Full global-clock pulse; with positive polarity the edge lands on the rise.
    task automatic gedge();
        glb_clk = 1'b1; tick();
        glb_clk = 1'b0; tick();
    endtask

    task automatic set_q(input logic v);
        glb_rst = ~v; glb_pre = v;
        gedge();
        glb_rst = 1'b0; glb_pre = 1'b0;
    endtask

    function automatic logic model(input int kind, input logic q, input logic a, input logic b);
        if (kind == 1) return q ^ a;
        if (kind == 2) begin
            if (a && b) return ~q;
            if (a) return 1'b1;
            if (b) return 1'b0;
            return q;
        end
        return a;
    endfunction

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        {sum_a, sum_b, sum_c, sum_d} = 4'b0;
        glb_clk = 1'b0; glb_clk_neg = 1'b0;
        glb_rst = 1'b0; glb_pre = 1'b0; glb_load = 1'b0;
        cfg_kind = 2'd0; cfg_dyn_en = 1'b0; cfg_b_role = 2'd1;
        cfg_c_role = 1'b0; cfg_d_role = 1'b0; cfg_clk_src = 2'd0;
        cfg_out_sel = 4'b0000;
        @(negedge clk); tick(); tick();
        rst = 1'b0; tick();
        chk("R1 reset state", cell_out[0], 1'b0);

        // R2 R3 R4: kind sweep with every start state and A/B pair, including kind 3
        for (int kind = 0; kind < 4; kind++) begin
            for (int q0 = 0; q0 < 2; q0++) begin
                for (int ab = 0; ab < 4; ab++) begin
                    cfg_kind = 2'(kind);
                    set_q(1'(q0));
                    sum_a = ab[1]; sum_b = ab[0];
                    gedge();
                    chk(kind == 1 ? "R3 T kind" : (kind == 2 ? "R4 JK kind" : "R2 D kind"),
                        cell_out[0], model(kind == 3 ? 0 : kind, 1'(q0), ab[1], ab[0]));
                    sum_a = 1'b0; sum_b = 1'b0;
                end
            end
        end

        // R4: K forced 0 when B is not the K input
        cfg_kind = 2'd2; cfg_b_role = 2'd0;
        set_q(1'b1); sum_b = 1'b1; gedge();
        chk("R4 K ignored when B not K", cell_out[0], 1'b1);
        sum_b = 1'b0; cfg_b_role = 2'd1; cfg_kind = 2'd0;

        // R5: global reset/preset wait for an edge, reset wins
        set_q(1'b1);
        glb_rst = 1'b1; glb_pre = 1'b1; tick(); tick();
        chk("R5 no edge no effect", cell_out[0], 1'b1);
        gedge();
        chk("R5 reset over preset", cell_out[0], 1'b0);
        glb_rst = 1'b0; gedge();
        chk("R5 global preset", cell_out[0], 1'b1);
        glb_pre = 1'b0;

        // R6: immediate sum reset/preset
        set_q(1'b0);
        cfg_b_role = 2'd2; cfg_c_role = 1'b1;
        sum_b = 1'b1; #1;
        chk("R6 preset immediate", cell_out[0], 1'b1);
        sum_c = 1'b1; #1;
        chk("R6 reset over preset", cell_out[0], 1'b0);
        @(negedge clk);
        sum_b = 1'b0; sum_c = 1'b0; tick();
        chk("R6 reset kept", cell_out[0], 1'b0);
        sum_b = 1'b1; tick(); sum_b = 1'b0; tick();
        chk("R6 preset kept", cell_out[0], 1'b1);
        cfg_b_role = 2'd1; cfg_c_role = 1'b0;

        // R7: clock source selection
        set_q(1'b0);
        cfg_clk_src = 2'd1; tick();
        sum_a = 1'b1; sum_c = 1'b1; tick(); sum_c = 1'b0; tick();
        chk("R7 sum C clocks", cell_out[0], 1'b1);
        sum_a = 1'b0; gedge();
        chk("R7 global ignored", cell_out[0], 1'b1);
        sum_d = 1'b1; tick(); sum_d = 1'b0; tick();
        chk("R7 sum D ignored", cell_out[0], 1'b1);
        cfg_clk_src = 2'd2; tick();
        sum_d = 1'b1; tick(); sum_d = 1'b0; tick();
        chk("R7 sum D clocks", cell_out[0], 1'b0);
        cfg_clk_src = 2'd3; tick();
        sum_a = 1'b1; gedge();
        sum_c = 1'b1; sum_d = 1'b1; tick(); sum_c = 1'b0; sum_d = 1'b0; tick();
        chk("R7 no source", cell_out[0], 1'b0);
        sum_a = 1'b0; cfg_clk_src = 2'd0; tick();

        // R8: negative polarity
        set_q(1'b0);
        glb_clk = 1'b1; tick();
        glb_clk_neg = 1'b1; sum_a = 1'b1; tick();
        chk("R8 flip no edge", cell_out[0], 1'b0);
        glb_clk = 1'b0; tick();
        chk("R8 falling edge active", cell_out[0], 1'b1);
        sum_a = 1'b0; glb_clk = 1'b1; tick();
        chk("R8 rising edge ignored", cell_out[0], 1'b1);
        glb_clk = 1'b0; tick();
        chk("R8 falling edge loads", cell_out[0], 1'b0);
        glb_clk_neg = 1'b0; tick();

        // R9: run-time kind override
        cfg_kind = 2'd2; cfg_dyn_en = 1'b1; glb_load = 1'b1;
        set_q(1'b0);
        sum_a = 1'b1; gedge();
        chk("R9 load as D", cell_out[0], 1'b1);
        glb_load = 1'b0; gedge();
        chk("R9 count as T", cell_out[0], 1'b0);
        gedge();
        chk("R9 count again", cell_out[0], 1'b1);
        sum_a = 1'b0; gedge();
        chk("R9 T hold", cell_out[0], 1'b1);
        cfg_dyn_en = 1'b0; cfg_kind = 2'd0;

        // R12: no edge, data changes ignored
        set_q(1'b0);
        for (int n = 0; n < 4; n++) begin
            sum_a = 1'(n); sum_b = 1'(n >> 1); tick();
        end
        chk("R12 hold without edge", cell_out[0], 1'b0);
        sum_a = 1'b0; sum_b = 1'b0;

        // R10: output selection sweep
        cfg_b_role = 2'd0;
        for (int s = 0; s < 8; s++) begin
            sum_a = s[2]; sum_b = s[1]; sum_c = s[0];
            cfg_out_sel = {2'd3, 2'd2}; #1;
            chk("R10 out0 sum B", cell_out[0], s[1]);
            chk("R10 out1 sum C", cell_out[1], s[0]);
            cfg_out_sel = {2'd0, 2'd1}; #1;
            chk("R10 out0 sum A", cell_out[0], s[2]);
            chk("R10 out1 state", cell_out[1], 1'b0);
        end
        {sum_a, sum_b, sum_c} = 3'b0;
        @(negedge clk);

        // R11: sum D roles
        for (int v = 0; v < 2; v++) begin
            sum_d = 1'(v);
            cfg_d_role = 1'b1; #1;
            chk("R11 oe follows D", oe_o, 1'(v));
            chk("R11 fb low", fb_o, 1'b0);
            cfg_d_role = 1'b0; #1;
            chk("R11 fb follows D", fb_o, 1'(v));
            chk("R11 oe high", oe_o, 1'b1);
        end
        sum_d = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule